// File: doc/BRIEF.md
# Link Training State Sequencer

This block steps a serial link from power-up to normal traffic. It holds a 4-bit main state and a 3-bit substate and drives both out as status. Its inputs are abstract events: the receiver has left electrical idle, receiver detection has finished (with an all-lanes or some-lanes result), a TS1, a TS2 or an idle symbol has arrived, the link and lane numbers of the arriving ordered set match, and the higher layer asks for retraining. Its outputs are commands: transmit TS1, TS2 or idles, transmit the compliance pattern, start receiver detection, and link-up.

Every main state opens with a one-cycle wait substate (000) and closes with a one-cycle exit substate that hands over to the next main state. One counter measures the time spent in the current substate and restarts whenever the substate changes. Each timeout is a parameter in clock cycles, so a simulation can use short windows. Ordered sets sent are counted one per cycle of an active transmit command. Ordered sets received are counted one per cycle of a qualifying input event. Both counts restart on every substate change.

Top module: `link_train_seq`

## Requirements
- R1: While reset is held, the main state is 0000, the substate is 000, and every command output and link-up is low.
- R2: The main state codes are DETECT 0000, POLLING 0001, CONFIGURATION 0010, L0 0011 and RECOVERY 0111. Each main state enters substate 000 for exactly one cycle. The main state changes only from its exit substate, and that exit substate lasts one cycle. The exit codes are DETECT 111, POLLING 100, CONFIGURATION 111, L0 110 and RECOVERY 100.
- R3: In DETECT substate 001 the block stays until the receiver leaves electrical idle or T_12MS cycles have passed, then moves to 010.
- R4: In DETECT 010 and 101 the start-detect command is high for T_DET cycles, then the block moves to 011 or 110. In 011, a finished detection with all lanes found goes to 111. A finished detection with only some lanes found goes to 100, which lasts T_12MS cycles and then moves to 101. A finished detection with no lanes found goes to 001. In 110, any lanes found goes to 111 and none goes to 001.
- R5: In POLLING 001 the block sends TS1. It moves to 011 once TS1_BURST TS1s have been sent and RX_MIN TS1/TS2 have been received. After T_24MS cycles there, it enters compliance (010) if no electrical-idle exit was seen in the substate; otherwise it goes to DETECT. Compliance sends the compliance pattern until an electrical-idle exit returns it to 001.
- R6: In POLLING 011 the block sends TS2. After RX_MIN TS2s received and TX_MIN sent, it goes to CONFIGURATION. After T_48MS cycles without that, it goes to DETECT. Either way it passes through exit substate 100.
- R7: CONFIGURATION moves 001 to 010 on a TS1 with matching link number, 010 to 011 on a TS1 with both numbers matching, 011 to 100 on a TS2 with both numbers matching, and 100 to 101 after one cycle. Timeouts to DETECT (through 111) are T_24MS in 001 and T_2MS in 010 and 011.
- R8: CONFIGURATION 101 sends TS2 and needs RX_MIN TS2s with both numbers matching plus TX_MIN sent, then moves to 110. 110 sends idles and needs RX_MIN idles plus TX_MIN sent, then goes to L0. Either substate goes to DETECT after T_2MS cycles.
- R9: Link-up is high exactly when the state is L0 with substate 001. A TS1, a TS2 or a retrain request there moves the block through 110 into RECOVERY.
- R10: RECOVERY runs three phases. 001 sends TS1 and needs RX_MIN TS1/TS2 plus TS1_BURST sent within T_24MS. 010 sends TS2 and needs RX_MIN TS2 plus TX_MIN sent within T_48MS. 011 sends idles and needs RX_MIN idles plus TX_MIN sent within T_2MS. Success goes to L0 and any timeout goes to DETECT, both through 100.
- R11: The timeout counter restarts on every substate change, so each timeout is measured from entry into its own substate.
- R12: At most one of the transmit-TS1, transmit-TS2, transmit-idle, compliance and start-detect commands is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_eidle_exit | input | 1 | Receiver has left electrical idle |
| det_done | input | 1 | Receiver detection finished this cycle |
| det_all | input | 1 | Detection result: all lanes found |
| det_some | input | 1 | Detection result: some but not all lanes found |
| rx_ts1 | input | 1 | A TS1 arrived this cycle |
| rx_ts2 | input | 1 | A TS2 arrived this cycle |
| rx_idle | input | 1 | An idle symbol arrived this cycle |
| link_num_ok | input | 1 | Link number of the arriving ordered set matches |
| lane_num_ok | input | 1 | Lane number of the arriving ordered set matches |
| retrain_req | input | 1 | Higher layer asks for retraining |
| ltssm_main | output | 4 | Main state code |
| ltssm_sub | output | 3 | Substate code |
| tx_ts1 | output | 1 | Send TS1 ordered sets |
| tx_ts2 | output | 1 | Send TS2 ordered sets |
| tx_idle | output | 1 | Send idle symbols |
| tx_compliance | output | 1 | Send the compliance pattern |
| rxdet_start | output | 1 | Run receiver detection |
| link_up | output | 1 | Link trained and in normal traffic |

## Verification
The assertions check several rules on every cycle: the one-cycle wait substate, main-state changes only from the matching exit substate, a zero timer on each substate entry, link-up rising only straight after the L0 wait, at most one command, and received counts that never pass their cap. Only the bench scenarios can show the timing and the choice of branch. Those scenarios measure the exact length of each timeout window from substate entry and follow the partial-detect retry. They also cover the choice between compliance and DETECT on a polling timeout, and a full training pass into L0, out through RECOVERY and back.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef enum logic [3:0] {
    M_DETECT = 4'd0,
    M_POLL   = 4'd1,
    M_CONFIG = 4'd2,
    M_L0     = 4'd3,
    M_L0S    = 4'd4,
    M_L1     = 4'd5,
    M_L2     = 4'd6,
    M_RECOV  = 4'd7
  } main_e;

  localparam logic [2:0] S_WAIT = 3'd0;

  // detect substates
  localparam logic [2:0] D_QUIET  = 3'd1;
  localparam logic [2:0] D_GO1    = 3'd2;
  localparam logic [2:0] D_ACT1   = 3'd3;
  localparam logic [2:0] D_WAIT12 = 3'd4;
  localparam logic [2:0] D_GO2    = 3'd5;
  localparam logic [2:0] D_ACT2   = 3'd6;
  localparam logic [2:0] D_EXIT   = 3'd7;

  // polling substates
  localparam logic [2:0] P_ACTIVE = 3'd1;
  localparam logic [2:0] P_COMPL  = 3'd2;
  localparam logic [2:0] P_CONFIG = 3'd3;
  localparam logic [2:0] P_EXIT   = 3'd4;

  // configuration substates
  localparam logic [2:0] C_LW_START = 3'd1;
  localparam logic [2:0] C_LW_ACC   = 3'd2;
  localparam logic [2:0] C_LN_WAIT  = 3'd3;
  localparam logic [2:0] C_LN_ACC   = 3'd4;
  localparam logic [2:0] C_COMPLETE = 3'd5;
  localparam logic [2:0] C_IDLE     = 3'd6;
  localparam logic [2:0] C_EXIT     = 3'd7;

  // normal traffic substates
  localparam logic [2:0] L_ACTIVE = 3'd1;
  localparam logic [2:0] L_EXIT   = 3'd6;

  // recovery substates
  localparam logic [2:0] V_LOCK = 3'd1;
  localparam logic [2:0] V_CFG  = 3'd2;
  localparam logic [2:0] V_IDLE = 3'd3;
  localparam logic [2:0] V_EXIT = 3'd4;

  typedef struct packed {
    logic ts1;
    logic ts2;
    logic idle;
    logic compl;
    logic rxdet;
  } txcmd_t;

  function automatic logic [2:0] exit_code(input main_e m);
    case (m)
      M_DETECT: exit_code = D_EXIT;
      M_POLL:   exit_code = P_EXIT;
      M_CONFIG: exit_code = C_EXIT;
      M_L0:     exit_code = L_EXIT;
      M_RECOV:  exit_code = V_EXIT;
      default:  exit_code = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/lts_timer.sv
module lts_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [TW-1:0] cnt
);

  localparam logic [TW-1:0] TOP = {TW{1'b1}};

  logic [TW-1:0] cnt_d;

  always_comb begin
    if (restart)          cnt_d = '0;
    else if (cnt != TOP)  cnt_d = cnt + 1'b1;
    else                  cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/lts_evcount.sv
module lts_evcount #(
  parameter int TXW    = 4,
  parameter int RXW    = 4,
  parameter int TX_CAP = 8,
  parameter int RX_CAP = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           tx_inc,
  input  logic           rx_inc,
  input  logic           eidle_in,
  output logic [TXW-1:0] tx_cnt,
  output logic [RXW-1:0] rx_cnt,
  output logic           eidle_seen
);

  localparam logic [TXW-1:0] TX_TOP = TXW'(TX_CAP);
  localparam logic [RXW-1:0] RX_TOP = RXW'(RX_CAP);

  logic [TXW-1:0] tx_d;
  logic [RXW-1:0] rx_d;
  logic           seen_d;

  always_comb begin
    tx_d   = tx_cnt;
    rx_d   = rx_cnt;
    seen_d = eidle_seen | eidle_in;
    if (restart) begin
      tx_d   = '0;
      rx_d   = '0;
      seen_d = 1'b0;
    end else begin
      if (tx_inc && tx_cnt != TX_TOP) tx_d = tx_cnt + 1'b1;
      if (rx_inc && rx_cnt != RX_TOP) rx_d = rx_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt     <= '0;
      rx_cnt     <= '0;
      eidle_seen <= 1'b0;
    end else begin
      tx_cnt     <= tx_d;
      rx_cnt     <= rx_d;
      eidle_seen <= seen_d;
    end
  end

  // R8
  rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RX_TOP);

  // R5
  tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_TOP);

endmodule

// File: rtl/lts_fsm.sv
module lts_fsm
  import lts_pkg::*;
#(
  parameter int TW        = 8,
  parameter int TXW       = 4,
  parameter int RXW       = 4,
  parameter int T_DET     = 4,
  parameter int T_2MS     = 60,
  parameter int T_12MS    = 100,
  parameter int T_24MS    = 200,
  parameter int T_48MS    = 300,
  parameter int TS1_BURST = 32,
  parameter int TX_MIN    = 16,
  parameter int RX_MIN    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_eidle_exit,
  input  logic           det_done,
  input  logic           det_all,
  input  logic           det_some,
  input  logic           rx_ts1,
  input  logic           rx_ts2,
  input  logic           rx_idle,
  input  logic           link_num_ok,
  input  logic           lane_num_ok,
  input  logic           retrain_req,
  input  logic [TW-1:0]  tmr_cnt,
  input  logic [TXW-1:0] tx_cnt,
  input  logic [RXW-1:0] rx_cnt,
  input  logic           eidle_seen,
  output main_e          main_q,
  output logic [2:0]     sub_q,
  output logic           restart,
  output txcmd_t         cmd,
  output logic           rx_inc,
  output logic           link_up
);

  localparam logic [TW-1:0]  LIM_DET = TW'(T_DET - 1);
  localparam logic [TW-1:0]  LIM_2   = TW'(T_2MS - 1);
  localparam logic [TW-1:0]  LIM_12  = TW'(T_12MS - 1);
  localparam logic [TW-1:0]  LIM_24  = TW'(T_24MS - 1);
  localparam logic [TW-1:0]  LIM_48  = TW'(T_48MS - 1);
  localparam logic [TXW-1:0] NB_TS1  = TXW'(TS1_BURST);
  localparam logic [TXW-1:0] NB_TX   = TXW'(TX_MIN);
  localparam logic [RXW-1:0] NB_RX   = RXW'(RX_MIN);

  main_e      main_d, exit_q, exit_d;
  logic [2:0] sub_d;
  logic       hit_det, hit_2, hit_12, hit_24, hit_48;
  logic       burst_ok, short_ok, both_num;

  assign hit_det  = (tmr_cnt == LIM_DET);
  assign hit_2    = (tmr_cnt == LIM_2);
  assign hit_12   = (tmr_cnt == LIM_12);
  assign hit_24   = (tmr_cnt == LIM_24);
  assign hit_48   = (tmr_cnt == LIM_48);
  assign burst_ok = (tx_cnt >= NB_TS1) && (rx_cnt >= NB_RX);
  assign short_ok = (tx_cnt >= NB_TX) && (rx_cnt >= NB_RX);
  assign both_num = link_num_ok && lane_num_ok;

  always_comb begin
    main_d  = main_q;
    sub_d   = sub_q;
    exit_d  = exit_q;
    cmd     = '0;
    rx_inc  = 1'b0;
    link_up = 1'b0;
    if (sub_q != S_WAIT && sub_q == exit_code(main_q)) begin
      main_d = exit_q;
      sub_d  = S_WAIT;
    end else begin
      case (main_q)
        M_DETECT: begin
          case (sub_q)
            S_WAIT:   sub_d = D_QUIET;
            D_QUIET:  if (rx_eidle_exit || hit_12) sub_d = D_GO1;
            D_GO1: begin
              cmd.rxdet = 1'b1;
              if (hit_det) sub_d = D_ACT1;
            end
            D_ACT1: if (det_done) begin
              if (det_all) begin
                sub_d = D_EXIT; exit_d = M_POLL;
              end else if (det_some) sub_d = D_WAIT12;
              else                   sub_d = D_QUIET;
            end
            D_WAIT12: if (hit_12) sub_d = D_GO2;
            D_GO2: begin
              cmd.rxdet = 1'b1;
              if (hit_det) sub_d = D_ACT2;
            end
            D_ACT2: if (det_done) begin
              if (det_all || det_some) begin
                sub_d = D_EXIT; exit_d = M_POLL;
              end else sub_d = D_QUIET;
            end
            default: sub_d = S_WAIT;
          endcase
        end
        M_POLL: begin
          case (sub_q)
            S_WAIT: sub_d = P_ACTIVE;
            P_ACTIVE: begin
              cmd.ts1 = 1'b1;
              rx_inc  = rx_ts1 || rx_ts2;
              if (burst_ok) sub_d = P_CONFIG;
              else if (hit_24) begin
                if (eidle_seen || rx_eidle_exit) begin
                  sub_d = P_EXIT; exit_d = M_DETECT;
                end else sub_d = P_COMPL;
              end
            end
            P_COMPL: begin
              cmd.compl = 1'b1;
              if (rx_eidle_exit) sub_d = P_ACTIVE;
            end
            P_CONFIG: begin
              cmd.ts2 = 1'b1;
              rx_inc  = rx_ts2;
              if (short_ok) begin
                sub_d = P_EXIT; exit_d = M_CONFIG;
              end else if (hit_48) begin
                sub_d = P_EXIT; exit_d = M_DETECT;
              end
            end
            default: begin sub_d = P_EXIT; exit_d = M_DETECT; end
          endcase
        end
        M_CONFIG: begin
          case (sub_q)
            S_WAIT: sub_d = C_LW_START;
            C_LW_START: begin
              cmd.ts1 = 1'b1;
              if (rx_ts1 && link_num_ok) sub_d = C_LW_ACC;
              else if (hit_24) begin sub_d = C_EXIT; exit_d = M_DETECT; end
            end
            C_LW_ACC: begin
              cmd.ts1 = 1'b1;
              if (rx_ts1 && both_num) sub_d = C_LN_WAIT;
              else if (hit_2) begin sub_d = C_EXIT; exit_d = M_DETECT; end
            end
            C_LN_WAIT: begin
              cmd.ts1 = 1'b1;
              if (rx_ts2 && both_num) sub_d = C_LN_ACC;
              else if (hit_2) begin sub_d = C_EXIT; exit_d = M_DETECT; end
            end
            C_LN_ACC: begin
              cmd.ts2 = 1'b1;
              sub_d   = C_COMPLETE;
            end
            C_COMPLETE: begin
              cmd.ts2 = 1'b1;
              rx_inc  = rx_ts2 && both_num;
              if (short_ok) sub_d = C_IDLE;
              else if (hit_2) begin sub_d = C_EXIT; exit_d = M_DETECT; end
            end
            C_IDLE: begin
              cmd.idle = 1'b1;
              rx_inc   = rx_idle;
              if (short_ok) begin sub_d = C_EXIT; exit_d = M_L0; end
              else if (hit_2) begin sub_d = C_EXIT; exit_d = M_DETECT; end
            end
            default: begin sub_d = C_EXIT; exit_d = M_DETECT; end
          endcase
        end
        M_L0: begin
          case (sub_q)
            S_WAIT: sub_d = L_ACTIVE;
            L_ACTIVE: begin
              link_up = 1'b1;
              if (rx_ts1 || rx_ts2 || retrain_req) begin
                sub_d = L_EXIT; exit_d = M_RECOV;
              end
            end
            default: begin sub_d = L_EXIT; exit_d = M_DETECT; end
          endcase
        end
        M_RECOV: begin
          case (sub_q)
            S_WAIT: sub_d = V_LOCK;
            V_LOCK: begin
              cmd.ts1 = 1'b1;
              rx_inc  = rx_ts1 || rx_ts2;
              if (burst_ok) sub_d = V_CFG;
              else if (hit_24) begin sub_d = V_EXIT; exit_d = M_DETECT; end
            end
            V_CFG: begin
              cmd.ts2 = 1'b1;
              rx_inc  = rx_ts2;
              if (short_ok) sub_d = V_IDLE;
              else if (hit_48) begin sub_d = V_EXIT; exit_d = M_DETECT; end
            end
            V_IDLE: begin
              cmd.idle = 1'b1;
              rx_inc   = rx_idle;
              if (short_ok) begin sub_d = V_EXIT; exit_d = M_L0; end
              else if (hit_2) begin sub_d = V_EXIT; exit_d = M_DETECT; end
            end
            default: begin sub_d = V_EXIT; exit_d = M_DETECT; end
          endcase
        end
        default: begin
          main_d = M_DETECT;
          sub_d  = S_WAIT;
        end
      endcase
    end
  end

  assign restart = (main_d != main_q) || (sub_d != sub_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= M_DETECT;
      sub_q  <= S_WAIT;
      exit_q <= M_DETECT;
    end else begin
      main_q <= main_d;
      sub_q  <= sub_d;
      exit_q <= exit_d;
    end
  end

  // R2
  wait_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q == S_WAIT) |=> (sub_q != S_WAIT));

  // R2
  main_from_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q != $past(main_q)) |->
      ($past(sub_q) == exit_code($past(main_q)) && sub_q == S_WAIT));

  // R11
  timer_entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q != $past(main_q) || sub_q != $past(sub_q)) |-> (tmr_cnt == '0));

  // R12
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));

  // R9
  linkup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> ($past(main_q) == M_L0 && $past(sub_q) == S_WAIT));

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lts_pkg::*;
#(
  parameter int T_DET     = 15,
  parameter int T_2MS     = 250000,
  parameter int T_12MS    = 1500000,
  parameter int T_24MS    = 3000000,
  parameter int T_48MS    = 6000000,
  parameter int TS1_BURST = 1024,
  parameter int TX_MIN    = 16,
  parameter int RX_MIN    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_eidle_exit,
  input  logic       det_done,
  input  logic       det_all,
  input  logic       det_some,
  input  logic       rx_ts1,
  input  logic       rx_ts2,
  input  logic       rx_idle,
  input  logic       link_num_ok,
  input  logic       lane_num_ok,
  input  logic       retrain_req,
  output logic [3:0] ltssm_main,
  output logic [2:0] ltssm_sub,
  output logic       tx_ts1,
  output logic       tx_ts2,
  output logic       tx_idle,
  output logic       tx_compliance,
  output logic       rxdet_start,
  output logic       link_up
);

  localparam int TMAX_A = (T_12MS > T_2MS) ? T_12MS : T_2MS;
  localparam int TMAX_B = (T_48MS > T_24MS) ? T_48MS : T_24MS;
  localparam int TMAX_C = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMAX   = (TMAX_C > T_DET) ? TMAX_C : T_DET;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int TX_CAP = (TS1_BURST > TX_MIN) ? TS1_BURST : TX_MIN;
  localparam int TXW    = $clog2(TX_CAP + 1);
  localparam int RXW    = $clog2(RX_MIN + 1);

  logic [1:0]     rst_sync;
  logic           rst_core_n;
  logic [TW-1:0]  tmr_cnt;
  logic [TXW-1:0] tx_cnt;
  logic [RXW-1:0] rx_cnt;
  logic           eidle_seen, restart, rx_inc;
  main_e          main_q;
  logic [2:0]     sub_q;
  txcmd_t         cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  lts_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (restart),
    .cnt     (tmr_cnt)
  );

  lts_evcount #(
    .TXW(TXW), .RXW(RXW), .TX_CAP(TX_CAP), .RX_CAP(RX_MIN)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .restart    (restart),
    .tx_inc     (cmd.ts1 | cmd.ts2 | cmd.idle),
    .rx_inc     (rx_inc),
    .eidle_in   (rx_eidle_exit),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .eidle_seen (eidle_seen)
  );

  lts_fsm #(
    .TW(TW), .TXW(TXW), .RXW(RXW), .T_DET(T_DET), .T_2MS(T_2MS),
    .T_12MS(T_12MS), .T_24MS(T_24MS), .T_48MS(T_48MS),
    .TS1_BURST(TS1_BURST), .TX_MIN(TX_MIN), .RX_MIN(RX_MIN)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .rx_eidle_exit (rx_eidle_exit),
    .det_done      (det_done),
    .det_all       (det_all),
    .det_some      (det_some),
    .rx_ts1        (rx_ts1),
    .rx_ts2        (rx_ts2),
    .rx_idle       (rx_idle),
    .link_num_ok   (link_num_ok),
    .lane_num_ok   (lane_num_ok),
    .retrain_req   (retrain_req),
    .tmr_cnt       (tmr_cnt),
    .tx_cnt        (tx_cnt),
    .rx_cnt        (rx_cnt),
    .eidle_seen    (eidle_seen),
    .main_q        (main_q),
    .sub_q         (sub_q),
    .restart       (restart),
    .cmd           (cmd),
    .rx_inc        (rx_inc),
    .link_up       (link_up)
  );

  assign ltssm_main    = main_q;
  assign ltssm_sub     = sub_q;
  assign tx_ts1        = cmd.ts1;
  assign tx_ts2        = cmd.ts2;
  assign tx_idle       = cmd.idle;
  assign tx_compliance = cmd.compl;
  assign rxdet_start   = cmd.rxdet;

endmodule

// File: tb/link_train_seq_test.sv
module link_train_seq_test;

  localparam int P_DET = 4;
  localparam int P_2   = 60;
  localparam int P_12  = 100;
  localparam int P_24  = 200;
  localparam int P_48  = 300;
  localparam int P_B   = 32;
  localparam int P_TX  = 16;
  localparam int P_RX  = 8;

  // drive bits: 9 eidle, 8 done, 7 all, 6 some, 5 ts1, 4 ts2, 3 idle, 2 link ok, 1 lane ok, 0 retrain
  typedef struct packed {
    logic [9:0] drv;
    logic [3:0] m;
    logic [2:0] s;
    logic       lu;
  } step_t;

  localparam int NSTEP = 16;
  localparam step_t PATH [0:NSTEP-1] = '{
    '{10'h000, 4'd0, 3'd1, 1'b0},
    '{10'h200, 4'd0, 3'd2, 1'b0},
    '{10'h200, 4'd0, 3'd3, 1'b0},
    '{10'h380, 4'd0, 3'd7, 1'b0},
    '{10'h200, 4'd1, 3'd1, 1'b0},
    '{10'h220, 4'd1, 3'd3, 1'b0},
    '{10'h210, 4'd2, 3'd1, 1'b0},
    '{10'h224, 4'd2, 3'd2, 1'b0},
    '{10'h226, 4'd2, 3'd3, 1'b0},
    '{10'h216, 4'd2, 3'd5, 1'b0},
    '{10'h216, 4'd2, 3'd6, 1'b0},
    '{10'h208, 4'd3, 3'd1, 1'b1},
    '{10'h220, 4'd7, 3'd1, 1'b0},
    '{10'h220, 4'd7, 3'd2, 1'b0},
    '{10'h210, 4'd7, 3'd3, 1'b0},
    '{10'h208, 4'd3, 3'd1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] drv = '0;
  logic [3:0] ltssm_main;
  logic [2:0] ltssm_sub;
  logic       tx_ts1, tx_ts2, tx_idle, tx_compliance, rxdet_start, link_up;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit mon_on = 1'b0;
  int mon_cmd_bad = 0;
  int mon_wait_bad = 0;
  int mon_exit_bad = 0;
  int ts1_run = 0;
  int ts1_last = 0;
  logic [3:0] pm;
  logic [2:0] ps;

  always #2.5 clk = ~clk;

  link_train_seq #(
    .T_DET(P_DET), .T_2MS(P_2), .T_12MS(P_12), .T_24MS(P_24), .T_48MS(P_48),
    .TS1_BURST(P_B), .TX_MIN(P_TX), .RX_MIN(P_RX)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_eidle_exit (drv[9]),
    .det_done      (drv[8]),
    .det_all       (drv[7]),
    .det_some      (drv[6]),
    .rx_ts1        (drv[5]),
    .rx_ts2        (drv[4]),
    .rx_idle       (drv[3]),
    .link_num_ok   (drv[2]),
    .lane_num_ok   (drv[1]),
    .retrain_req   (drv[0]),
    .ltssm_main    (ltssm_main),
    .ltssm_sub     (ltssm_sub),
    .tx_ts1        (tx_ts1),
    .tx_ts2        (tx_ts2),
    .tx_idle       (tx_idle),
    .tx_compliance (tx_compliance),
    .rxdet_start   (rxdet_start),
    .link_up       (link_up)
  );

  function automatic logic [2:0] exit_of(input logic [3:0] m);
    case (m)
      4'd0: exit_of = 3'd7;
      4'd1: exit_of = 3'd4;
      4'd2: exit_of = 3'd7;
      4'd3: exit_of = 3'd6;
      default: exit_of = 3'd4;
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic goto(input logic [9:0] d, input int m, input int s, input int lim, output bit hit);
    drv = d;
    hit = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (ltssm_main == 4'(m) && ltssm_sub == 3'(s)) begin
        hit = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic count_in(input int m, input int s, input int lim, output int n);
    n = 0;
    while (ltssm_main == 4'(m) && ltssm_sub == 3'(s) && n < lim) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic reach(input logic [9:0] d, input int m, input int s, input int lim, input string req);
    bit h;
    goto(d, m, s, lim, h);
    check(h, req, {ltssm_main, 1'b0, ltssm_sub}, (m << 4) | s);
  endtask

  task automatic do_reset();
    mon_on = 1'b0;
    drv = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ltssm_main == 4'd0 && ltssm_sub == 3'd0, "R1 state", {ltssm_main, 1'b0, ltssm_sub}, 0);
    check({tx_ts1, tx_ts2, tx_idle, tx_compliance, rxdet_start, link_up} == 6'b0,
          "R1 outputs", {tx_ts1, tx_ts2, tx_idle, tx_compliance, rxdet_start, link_up}, 0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if ($countones({tx_ts1, tx_ts2, tx_idle, tx_compliance, rxdet_start}) > 1) mon_cmd_bad++;
      if (pm == ltssm_main && ps == 3'd0 && ltssm_sub == 3'd0) mon_wait_bad++;
      if (pm != ltssm_main && (ps != exit_of(pm) || ltssm_sub != 3'd0)) mon_exit_bad++;
      if (ltssm_main == 4'd1 && ltssm_sub == 3'd1) begin
        if (tx_ts1) ts1_run++;
      end else if (pm == 4'd1 && ps == 3'd1) begin
        ts1_last = ts1_run;
        ts1_run = 0;
      end
    end
    pm = ltssm_main;
    ps = ltssm_sub;
  end

  initial begin
    int n;
    bit h;
    do_reset();
    // R2 R3 R4 R5 R6 R7 R8 R9 R10: full training walk
    for (int k = 0; k < NSTEP; k++) begin
      goto(PATH[k].drv, int'(PATH[k].m), int'(PATH[k].s), 80, h);
      mon_on = 1'b1;
      check(h && link_up == PATH[k].lu,
            $sformatf("path step %0d R2 R3 R4 R5 R6 R7 R8 R9 R10", k),
            {ltssm_main, 1'b0, ltssm_sub, link_up}, {PATH[k].m, 1'b0, PATH[k].s, PATH[k].lu});
    end
    // R5 TS1 burst length
    check(ts1_last >= P_B, "R5 ts1 sent", ts1_last, P_B);
    // R9 link stays up with no training sets
    drv = 10'h200;
    repeat (40) @(negedge clk);
    check(ltssm_main == 4'd3 && ltssm_sub == 3'd1 && link_up, "R9 hold L0", {ltssm_main, 1'b0, ltssm_sub}, 8'h31);
    reach(10'h001, 7, 1, 6, "R9 retrain to recovery");
    drv = '0;
    count_in(7, 1, 1000, n);
    check(n == P_24, "R10 lock timeout", n, P_24);
    reach(10'h000, 7, 4, 2, "R10 exit");
    reach(10'h000, 0, 0, 2, "R10 to detect");

    do_reset();
    goto(10'h000, 0, 1, 10, h);
    mon_on = 1'b1;
    count_in(0, 1, 1000, n);
    check(n == P_12, "R3 quiet timeout", n, P_12);
    check(ltssm_sub == 3'd2 && rxdet_start, "R4 detect start", {ltssm_sub, rxdet_start}, 5);
    count_in(0, 2, 1000, n);
    check(n == P_DET, "R4 detect window", n, P_DET);
    reach(10'h140, 0, 4, 3, "R4 partial detect");
    drv = '0;
    count_in(0, 4, 1000, n);
    check(n == P_12, "R4 partial wait", n, P_12);
    count_in(0, 5, 1000, n);
    check(n == P_DET, "R4 second detect", n, P_DET);
    reach(10'h100, 0, 1, 3, "R4 no lanes to quiet");

    reach(10'h000, 0, 3, 200, "R3 quiet timeout path");
    reach(10'h180, 1, 1, 4, "R5 enter polling");
    drv = '0;
    count_in(1, 1, 1000, n);
    check(n == P_24, "R5 active timeout", n, P_24);
    check(ltssm_sub == 3'd2 && tx_compliance, "R5 compliance", {ltssm_sub, tx_compliance}, 5);
    reach(10'h200, 1, 1, 3, "R5 compliance exit");
    reach(10'h220, 1, 3, 80, "R5 active done");
    drv = 10'h200;
    count_in(1, 3, 1000, n);
    check(n == P_48, "R6 config timeout", n, P_48);
    reach(10'h200, 1, 4, 2, "R6 exit");
    reach(10'h200, 0, 0, 2, "R6 to detect");

    reach(10'h200, 0, 3, 20, "R4 retrain detect");
    reach(10'h380, 1, 1, 4, "R5 polling again");
    reach(10'h220, 1, 3, 80, "R5 burst again");
    reach(10'h210, 2, 1, 40, "R6 to configuration");
    drv = 10'h200;
    repeat (20) @(negedge clk);
    reach(10'h224, 2, 2, 3, "R7 link number match");
    drv = 10'h200;
    count_in(2, 2, 1000, n);
    check(n == P_2, "R11 R7 timer restart", n, P_2);
    reach(10'h200, 2, 7, 2, "R7 exit");
    reach(10'h200, 0, 0, 2, "R7 to detect");

    // R12 R2 cycle monitors
    check(mon_cmd_bad == 0, "R12 single command", mon_cmd_bad, 0);
    check(mon_wait_bad == 0, "R2 wait one cycle", mon_wait_bad, 0);
    check(mon_exit_bad == 0, "R2 exit before change", mon_exit_bad, 0);
    summary();
    $finish;
  end

endmodule